// File: doc/BRIEF.md
# Sync-Gated Receive Byte FIFO

This block sits behind a bit demodulator in a packet radio receiver. It watches a stream of recovered bits, each marked by a one-cycle valid strobe, and hunts for a frame synchronisation word. Once the word is found, every later bit is shifted MSB first into a byte, and each completed byte goes into a small first-in first-out store that a host drains through a byte-read port. Sync hunting can be bypassed entirely, so that every bit is stored from the moment filling is enabled.

The sync word is either sixteen bits long, a fixed upper byte 0x2D followed by a programmable lower byte, or eight bits long, the lower byte alone. After one match the hunt stops, and every later bit is data, even if it repeats the sync pattern. To take the next packet, the host drops the fill enable for at least one cycle and raises it again. This re-arms the hunter, discards any partly assembled byte and clears the overflow flag. Bytes already in the store stay readable.

An active-low interrupt tells the host that enough data has arrived. It is computed from the number of bits held, counting both whole bytes and the byte still being assembled, against a 4-bit level.

Top module: `rxs_sync_fifo`

## Requirements
- R1: After reset the store is empty, `irq_n` is high and `overflow` is low.
- R2: With `cfg_sync_short` = 0, storage begins with the first bit after the sixteen bits 0x2D then `cfg_sync_lo` have arrived, oldest bit first. The lower byte alone does not start storage.
- R3: With `cfg_sync_short` = 1, storage begins with the first bit after the eight bits of `cfg_sync_lo` alone.
- R4: The lower sync byte is whatever `cfg_sync_lo` holds; values other than 0xD4 are matched just the same.
- R5: With `cfg_fill_always` = 1, bits are stored from the first valid bit, with no sync search.
- R6: While `cfg_fill_en` = 0, bits are neither searched nor stored and `overflow` clears. After a match, a later copy of the sync pattern is stored as data until the block is re-armed.
- R7: Bits are packed MSB first: the first stored bit becomes bit 7 of a byte. Bytes are read in arrival order. `rd_data` shows the oldest byte, and `rd_en` removes it.
- R8: `irq_n` is low exactly when 8 × (bytes held) + (bits in the partial byte) is at least `cfg_irq_level`; a level of 0 acts as 1.
- R9: A byte completing while the store holds DEPTH bytes, with no read in that cycle, is dropped and sets `overflow`. The flag stays set while `cfg_fill_en` = 1.
- R10: `rd_en` while the store is empty has no effect. The next stored byte is the first one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | One-cycle strobe marking a recovered bit |
| bit_in | input | 1 | Recovered bit value |
| cfg_sync_short | input | 1 | 1: eight-bit sync word, 0: sixteen-bit |
| cfg_sync_lo | input | 8 | Lower sync byte |
| cfg_fill_always | input | 1 | 1: store without sync |
| cfg_fill_en | input | 1 | Fill enable; low re-arms |
| cfg_irq_level | input | 4 | Bit count for interrupt |
| rd_en | input | 1 | Pop oldest byte |
| rd_data | output | 8 | Oldest byte held |
| irq_n | output | 1 | Fill-level interrupt, active low |
| overflow | output | 1 | Byte dropped on full store |

## Verification
The assertions take for granted that `cfg_irq_level` changes only while nothing is stored. Under that condition, a falling `irq_n` can only follow an accepted bit. They also take for granted that the configuration inputs stay stable within a packet. The bench changes configuration only after it has drained the store and re-armed the block, and it drives each bit and read request for exactly one cycle. A scoreboard queue holds the bytes the driver expects to be stored, and every read is compared against the head of that queue.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam logic [7:0] SYNC_HI = 8'h2D;

    typedef struct packed {
        logic [15:0] sh;
        logic [4:0]  n;
        logic        locked;
    } hunt_s;

    typedef struct packed {
        logic [7:0] acc;
        logic [2:0] cnt;
    } pack_s;
endpackage

// File: rtl/rxs_sync_hunt.sv
module rxs_sync_hunt
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       bit_in,
    input  logic       short_mode,
    input  logic [7:0] sync_lo,
    output logic       synced
);
    hunt_s h_d, h_q;
    logic [15:0] nsh;
    logic [4:0]  nn;
    logic        hit;

    always_comb begin
        h_d = h_q;
        nsh = {h_q.sh[14:0], bit_in};
        nn  = (h_q.n == 5'd16) ? h_q.n : h_q.n + 5'd1;
        if (short_mode)
            hit = (nn >= 5'd8) && (nsh[7:0] == sync_lo);
        else
            hit = (nn == 5'd16) && (nsh == {SYNC_HI, sync_lo});
        if (clear) begin
            h_d = '0;
        end else if (shift_en && !h_q.locked) begin
            h_d.sh = nsh;
            h_d.n  = nn;
            if (hit)
                h_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            h_q <= '0;
        else
            h_q <= h_d;
    end

    assign synced = h_q.locked;
endmodule

// File: rtl/rxs_packer.sv
module rxs_packer
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push_bit,
    input  logic       bit_in,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [2:0] nbits
);
    pack_s p_d, p_q;

    always_comb begin
        p_d       = p_q;
        byte_val  = {p_q.acc[6:0], bit_in};
        byte_done = push_bit && (p_q.cnt == 3'd7);
        if (clear) begin
            p_d = '0;
        end else if (push_bit) begin
            p_d.acc = byte_val;
            p_d.cnt = p_q.cnt + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            p_q <= '0;
        else
            p_q <= p_d;
    end

    assign nbits = p_q.cnt;
endmodule

// File: rtl/rxs_byte_fifo.sv
module rxs_byte_fifo #(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_ovf,
    input  logic          push,
    input  logic [7:0]    wdata,
    input  logic          pop,
    output logic [7:0]    rdata,
    output logic [CW-1:0] count,
    output logic          ovf
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
        logic                  ovf;
    } fifo_s;

    fifo_s f_d, f_q;
    logic  do_pop, do_push;

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && ((f_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) begin
            f_d.mem[f_q.wp] = wdata;
            f_d.wp          = f_q.wp + AW'(1);
        end
        if (do_pop)
            f_d.rp = f_q.rp + AW'(1);
        if (do_push && !do_pop)
            f_d.cnt = f_q.cnt + CW'(1);
        else if (do_pop && !do_push)
            f_d.cnt = f_q.cnt - CW'(1);
        if (clear_ovf)
            f_d.ovf = 1'b0;
        else if (push && !do_push)
            f_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            f_q <= '0;
        else
            f_q <= f_d;
    end

    assign rdata = f_q.mem[f_q.rp];
    assign count = f_q.cnt;
    assign ovf   = f_q.ovf;
endmodule

// File: rtl/rxs_sync_fifo.sv
module rxs_sync_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       cfg_sync_short,
    input  logic [7:0] cfg_sync_lo,
    input  logic       cfg_fill_always,
    input  logic       cfg_fill_en,
    input  logic [3:0] cfg_irq_level,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       irq_n,
    output logic       overflow
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int SBW = $clog2(DEPTH * 8 + 16);

    logic          synced, hunt_en, store_bit, byte_done;
    logic [7:0]    byte_val;
    logic [2:0]    nbits;
    logic [CW-1:0] fifo_count;
    logic [SBW-1:0] stored_bits, eff_level;

    assign hunt_en   = bit_valid && cfg_fill_en && !cfg_fill_always;
    assign store_bit = bit_valid && cfg_fill_en && (cfg_fill_always || synced);

    rxs_sync_hunt u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!cfg_fill_en),
        .shift_en   (hunt_en),
        .bit_in     (bit_in),
        .short_mode (cfg_sync_short),
        .sync_lo    (cfg_sync_lo),
        .synced     (synced)
    );

    rxs_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!cfg_fill_en),
        .push_bit  (store_bit),
        .bit_in    (bit_in),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .nbits     (nbits)
    );

    rxs_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_ovf (!cfg_fill_en),
        .push      (byte_done),
        .wdata     (byte_val),
        .pop       (rd_en),
        .rdata     (rd_data),
        .count     (fifo_count),
        .ovf       (overflow)
    );

    always_comb begin
        stored_bits = (SBW'(fifo_count) << 3) + SBW'(nbits);
        eff_level   = (cfg_irq_level == 4'd0) ? SBW'(1) : SBW'(cfg_irq_level);
        irq_n       = !(stored_bits >= eff_level);
    end
endmodule

// File: rtl/rxs_sync_fifo_chk.sv
module rxs_sync_fifo_chk #(
    parameter int DEPTH = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fill_en,
    input logic          bit_valid,
    input logic          rd_en,
    input logic          irq_n,
    input logic          overflow,
    input logic          push_req,
    input logic [CW-1:0] count
);
    assert_irq_needs_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(bit_valid));
    assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && fill_en) |=> overflow);
    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> !overflow);
    assert_idle_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !rd_en) |=> $stable(count));
    assert_count_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(count) == CW'(DEPTH) && $past(push_req)));
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_en && !push_req) |=> count == '0);
endmodule

bind rxs_sync_fifo rxs_sync_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (cfg_fill_en),
    .bit_valid (bit_valid),
    .rd_en     (rd_en),
    .irq_n     (irq_n),
    .overflow  (overflow),
    .push_req  (byte_done),
    .count     (fifo_count)
);

// File: tb/sim_rxs_sync_fifo.sv
module sim_rxs_sync_fifo;
    logic clk = 0, rst_n = 0;
    logic bit_valid = 0, bit_in = 0;
    logic cfg_sync_short = 0, cfg_fill_always = 0, cfg_fill_en = 0;
    logic [7:0] cfg_sync_lo = 8'hD4;
    logic [3:0] cfg_irq_level = 4'd8;
    logic rd_en = 0;
    logic [7:0] rd_data;
    logic irq_n, overflow;
    int checks = 0, errors = 0;
    logic [7:0] expq[$];

    always #4 clk = ~clk;

    rxs_sync_fifo #(.DEPTH(4)) u0 (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic keep);
        for (int i = 7; i >= 0; i--) begin
            bit_valid = 1; bit_in = b[i];
            @(negedge clk);
            bit_valid = 0;
        end
        if (keep) expq.push_back(b);
    endtask

    // monitor side of the scoreboard: compare head, then pop
    task automatic read_cmp(input string req);
        logic [7:0] e;
        e = expq.pop_front();
        check(rd_data == e, req, rd_data, e);
        rd_en = 1; @(negedge clk); rd_en = 0;
    endtask

    task automatic rearm();
        cfg_fill_en = 0; @(negedge clk); cfg_fill_en = 1; @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin @(negedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        check(irq_n == 1, "R1", irq_n, 1);
        check(overflow == 0, "R1", overflow, 0);

        // R2: two-byte sync
        cfg_fill_en = 1; @(negedge clk);
        send_byte(8'hAA, 0); send_byte(8'hAA, 0); send_byte(8'h2D, 0);
        check(irq_n == 1, "R2 no store before sync", irq_n, 1);
        send_byte(8'hD4, 0);
        check(irq_n == 1, "R2 sync not stored", irq_n, 1);
        send_byte(8'h5A, 1);
        check(irq_n == 0, "R2 byte after sync", irq_n, 0);
        read_cmp("R2");

        // R2 negative: low byte alone in long mode
        rearm();
        send_byte(8'hD4, 0); send_byte(8'h33, 0);
        check(irq_n == 1, "R2 low byte alone ignored", irq_n, 1);

        // R3 short mode, R6 repeated sync stored as data
        cfg_sync_short = 1; rearm();
        send_byte(8'hD4, 0); send_byte(8'hD4, 1); send_byte(8'h33, 1);
        read_cmp("R6 sync copy stored"); read_cmp("R3");

        // R4 programmable low byte
        cfg_sync_lo = 8'h96; rearm();
        send_byte(8'hD4, 0); send_byte(8'h96, 0); send_byte(8'hC3, 1);
        read_cmp("R4 short");
        cfg_sync_short = 0; rearm();
        send_byte(8'h2D, 0); send_byte(8'h96, 0); send_byte(8'h11, 1);
        read_cmp("R4 long");

        // R6: fill disabled, bits ignored
        cfg_fill_always = 1; cfg_fill_en = 0; cfg_irq_level = 4'd1; @(negedge clk);
        send_byte(8'hFF, 0);
        check(irq_n == 1, "R6 fill off ignored", irq_n, 1);

        // R5 fill always, R7 order
        cfg_fill_en = 1; @(negedge clk);
        send_byte(8'h12, 1); send_byte(8'h34, 1);
        read_cmp("R7 first"); read_cmp("R5 R7 second");

        // R8 levels
        cfg_irq_level = 4'd12; rearm();
        send_byte(8'hA5, 1);
        check(irq_n == 1, "R8 8 bits below 12", irq_n, 1);
        for (int i = 0; i < 3; i++) begin
            bit_valid = 1; bit_in = 1; @(negedge clk); bit_valid = 0;
        end
        check(irq_n == 1, "R8 11 bits", irq_n, 1);
        bit_valid = 1; bit_in = 0; @(negedge clk); bit_valid = 0;
        check(irq_n == 0, "R8 12 bits", irq_n, 0);
        read_cmp("R8 read");
        check(irq_n == 1, "R8 back below level", irq_n, 1);
        rearm();
        cfg_irq_level = 4'd0; @(negedge clk);
        check(irq_n == 1, "R8 level0 empty", irq_n, 1);
        bit_valid = 1; bit_in = 1; @(negedge clk); bit_valid = 0;
        check(irq_n == 0, "R8 level0 one bit", irq_n, 0);

        // R9 overflow
        cfg_irq_level = 4'd1; rearm();
        send_byte(8'h01, 1); send_byte(8'h02, 1); send_byte(8'h03, 1); send_byte(8'h04, 1);
        check(overflow == 0, "R9 full no ovf", overflow, 0);
        send_byte(8'h05, 0);
        check(overflow == 1, "R9 ovf set", overflow, 1);
        read_cmp("R9 a"); read_cmp("R9 b"); read_cmp("R9 c"); read_cmp("R9 d");
        check(overflow == 1, "R9 sticky", overflow, 1);
        check(irq_n == 1, "R9 dropped byte absent", irq_n, 1);
        cfg_fill_en = 0; @(negedge clk);
        check(overflow == 0, "R6 ovf clear", overflow, 0);
        cfg_fill_en = 1; @(negedge clk);

        // R10 empty read
        rd_en = 1; @(negedge clk); rd_en = 0;
        check(irq_n == 1, "R10 still empty", irq_n, 1);
        send_byte(8'h77, 1); send_byte(8'h88, 1);
        read_cmp("R10 first"); read_cmp("R10 second");
        check(irq_n == 1, "R10 drained", irq_n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule